// File: doc/BRIEF.md
# Single Bit Test-and-Modify Unit

This unit looks at one bit of a data word and, depending on a two-bit command, either only reports its state or also flips, clears or sets it. The caller presents a 32-bit operand, a bit number, a size flag (byte or long) and the command together with a valid strobe. One clock later the unit returns the updated word, a write strobe telling the caller whether that word has to be stored, and the condition flag vector. In that vector only the zero flag is recomputed. The other four flags come back exactly as they went in.

The bit number may be wider than the operand needs and may come from a register or from an immediate. Only its low bits count: three for a byte operand and five for a long operand, so the number wraps around the operand width. Fetching the operand and storing the result are the caller's job. In byte mode the upper 24 bits of the word are returned untouched.

The flag vector uses a fixed layout: bit 0 carry, bit 1 overflow, bit 2 zero, bit 3 negative, bit 4 extend.

Top module: `bittm_unit`

## Requirements
- R1: While `rst_n` is low, `res_valid`, `wr_en`, `result` and `flags_out` are all zero.
- R2: `res_valid` is high in the cycle after a cycle with `op_valid` high, and low in the cycle after a cycle with `op_valid` low. `wr_en` is low whenever `res_valid` is low.
- R3: With `size_long` = 0 the bit addressed is `bit_sel` modulo 8, so only bits 7..0 of the operand can be touched.
- R4: With `size_long` = 1 the bit addressed is `bit_sel` modulo 32.
- R5: Flag bit 2 (zero) of `flags_out` is 1 when the addressed bit of the original operand was 0, and 0 when it was 1.
- R6: Command 0 (test) gives `wr_en` = 0 and returns the operand unchanged in `result`.
- R7: Command 1 (toggle) inverts the addressed bit and gives `wr_en` = 1.
- R8: Command 2 (clear) forces the addressed bit to 0 and gives `wr_en` = 1.
- R9: Command 3 (set) forces the addressed bit to 1 and gives `wr_en` = 1.
- R10: Flag bits 4, 3, 1 and 0 (extend, negative, overflow, carry) of `flags_out` equal those of `flags_in` from the accepted cycle.
- R11: `result` differs from the accepted operand in at most one bit position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe; the inputs below are taken in this cycle |
| operand | input | 32 | Data word to test and modify |
| bit_sel | input | 8 | Bit number, reduced modulo the operand width |
| size_long | input | 1 | 1 = long operand (32 bits), 0 = byte operand (8 bits) |
| op_code | input | 2 | 0 test, 1 toggle, 2 clear, 3 set |
| flags_in | input | 5 | Current flags {X,N,Z,V,C} |
| res_valid | output | 1 | Result is available this cycle |
| result | output | 32 | Updated data word |
| wr_en | output | 1 | The caller must store `result` |
| flags_out | output | 5 | Flags with zero recomputed and the others unchanged |

## Verification
The hardest case to reach is a byte-mode bit number whose upper bits are not zero. A wrong reduction modulo the width would then pick a bit above bit 7 or wrap to the wrong bit. The vector table therefore uses bit numbers 9, 15 and 254 in byte mode. A sweep then walks bit numbers 0 to 63 in both sizes with the set command on a zero word, so every wrap point shows up directly in `result`. The zero flag is tested on both a set and a clear original bit, with the other flags held at patterns that would show any disturbance.

// File: rtl/bittm_pkg.sv
package bittm_pkg;

   typedef enum logic [1:0] {
      BOP_TEST = 2'd0,
      BOP_FLIP = 2'd1,
      BOP_CLR  = 2'd2,
      BOP_SET  = 2'd3
   } bop_e;

   localparam int FLAG_W = 5;
   localparam int FL_C   = 0;
   localparam int FL_V   = 1;
   localparam int FL_Z   = 2;
   localparam int FL_N   = 3;
   localparam int FL_X   = 4;

endpackage

// File: rtl/bittm_mask_gen.sv
module bittm_mask_gen #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int SEL_W  = 8
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic              size_long,
   output logic [DATA_W-1:0] mask
);
   localparam int IDX_W  = $clog2(DATA_W);
   localparam int BIDX_W = $clog2(BYTE_W);

   logic [IDX_W-1:0]  long_idx;
   logic [BIDX_W-1:0] byte_idx;
   logic [IDX_W-1:0]  idx;

   // Long index: keep the low IDX_W bits (modulo DATA_W) - R4
   if (SEL_W > IDX_W) begin : g_long_trunc
      logic unused_long_hi;
      assign unused_long_hi = ^sel[SEL_W-1:IDX_W];
      assign long_idx = sel[IDX_W-1:0];
   end else if (SEL_W == IDX_W) begin : g_long_exact
      assign long_idx = sel;
   end else begin : g_long_pad
      assign long_idx = {{(IDX_W-SEL_W){1'b0}}, sel};
   end

   // Byte index: keep the low BIDX_W bits (modulo BYTE_W) - R3
   if (SEL_W >= BIDX_W) begin : g_byte_trunc
      assign byte_idx = sel[BIDX_W-1:0];
   end else begin : g_byte_pad
      assign byte_idx = {{(BIDX_W-SEL_W){1'b0}}, sel};
   end

   assign idx  = size_long ? long_idx : {{(IDX_W-BIDX_W){1'b0}}, byte_idx};
   assign mask = {{(DATA_W-1){1'b0}}, 1'b1} << idx;

endmodule

// File: rtl/bittm_modify.sv
module bittm_modify
   import bittm_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] mask,
   input  bop_e              op,
   output logic [DATA_W-1:0] result,
   output logic              wr,
   output logic              z
);
   // Zero flag taken from the unmodified operand - R5
   assign z = ~|(operand & mask);

   always_comb begin
      result = operand;
      wr     = 1'b1;
      case (op)
         BOP_TEST: wr     = 1'b0;
         BOP_FLIP: result = operand ^ mask;
         BOP_CLR:  result = operand & ~mask;
         BOP_SET:  result = operand | mask;
         default:  wr     = 1'b0;
      endcase
   end

endmodule

// File: rtl/bittm_unit.sv
module bittm_unit
   import bittm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int SEL_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   input  logic [DATA_W-1:0]   operand,
   input  logic [SEL_W-1:0]    bit_sel,
   input  logic                size_long,
   input  logic [1:0]          op_code,
   input  logic [FLAG_W-1:0]   flags_in,
   output logic                res_valid,
   output logic [DATA_W-1:0]   result,
   output logic                wr_en,
   output logic [FLAG_W-1:0]   flags_out
);
   if ((DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("DATA_W must be a power of two");
   end
   if ((BYTE_W & (BYTE_W - 1)) != 0 || BYTE_W < 2 || BYTE_W >= DATA_W) begin : g_bad_byte_w
      $error("BYTE_W must be a power of two below DATA_W");
   end
   if (SEL_W < 1) begin : g_bad_sel_w
      $error("SEL_W must be at least 1");
   end

   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] mod_word;
   logic              mod_wr;
   logic              mod_z;
   logic [FLAG_W-1:0] next_flags;

   bittm_mask_gen #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W),
      .SEL_W  (SEL_W)
   ) u_mask (
      .sel       (bit_sel),
      .size_long (size_long),
      .mask      (mask)
   );

   bittm_modify #(
      .DATA_W (DATA_W)
   ) u_mod (
      .operand (operand),
      .mask    (mask),
      .op      (bop_e'(op_code)),
      .result  (mod_word),
      .wr      (mod_wr),
      .z       (mod_z)
   );

   always_comb begin
      next_flags       = flags_in;
      next_flags[FL_Z] = mod_z;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         wr_en     <= 1'b0;
         result    <= '0;
         flags_out <= '0;
      end else begin
         res_valid <= op_valid;
         wr_en     <= op_valid & mod_wr;
         if (op_valid) begin
            result    <= mod_word;
            flags_out <= next_flags;
         end
      end
   end

endmodule

// File: rtl/bittm_unit_chk.sv
module bittm_unit_chk
   import bittm_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [DATA_W-1:0] operand,
   input logic [1:0]        op_code,
   input logic [FLAG_W-1:0] flags_in,
   input logic              res_valid,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic [FLAG_W-1:0] flags_out
);
   localparam logic [FLAG_W-1:0] KEEP = ~(FLAG_W'(1) << FL_Z);

   p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);
   p_idle_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!res_valid && !wr_en));
   p_test_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'd0) |=> (!wr_en && result == $past(operand)));
   p_flip_z_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'd1) |=> (wr_en && (result != $past(operand)) &&
         (flags_out[FL_Z] == ($countones(result) > $countones($past(operand))))));
   p_clr_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'd2) |=> (wr_en && (result & ~$past(operand)) == '0));
   p_set_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'd3) |=> (wr_en && (result & $past(operand)) == $past(operand)));
   p_flags_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> ((flags_out & KEEP) == ($past(flags_in) & KEEP)));
   p_one_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> ($countones(result ^ $past(operand)) <= 1));

endmodule

bind bittm_unit bittm_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .operand   (operand),
   .op_code   (op_code),
   .flags_in  (flags_in),
   .res_valid (res_valid),
   .result    (result),
   .wr_en     (wr_en),
   .flags_out (flags_out)
);

// File: tb/bittm_unit_tb_top.sv
module bittm_unit_tb_top;

   typedef struct packed {
      logic [1:0]  op;
      logic        lng;
      logic [7:0]  sel;
      logic [31:0] opd;
      logic [4:0]  fin;
      logic [31:0] exp_res;
      logic        exp_wr;
      logic [4:0]  exp_fl;
   } vec_t;

   // flags {X,N,Z,V,C}; ops 0 test, 1 toggle, 2 clear, 3 set
   localparam vec_t VEC [8] = '{
      '{2'd0, 1'b1, 8'd5,   32'h0000_0020, 5'b00000, 32'h0000_0020, 1'b0, 5'b00000}, // R6 R5 bit=1
      '{2'd0, 1'b1, 8'd4,   32'h0000_0020, 5'b11011, 32'h0000_0020, 1'b0, 5'b11111}, // R6 R5 bit=0
      '{2'd1, 1'b1, 8'd31,  32'h8000_0001, 5'b00000, 32'h0000_0001, 1'b1, 5'b00000}, // R7 R4
      '{2'd1, 1'b0, 8'd9,   32'h0000_0000, 5'b10001, 32'h0000_0002, 1'b1, 5'b10101}, // R7 R3
      '{2'd2, 1'b1, 8'd40,  32'hFFFF_FFFF, 5'b01010, 32'hFFFF_FEFF, 1'b1, 5'b01010}, // R8 R4
      '{2'd2, 1'b0, 8'h0F,  32'h1234_5600, 5'b00000, 32'h1234_5600, 1'b1, 5'b00100}, // R8 R3
      '{2'd3, 1'b0, 8'hFE,  32'hAAAA_AA00, 5'b11011, 32'hAAAA_AA40, 1'b1, 5'b11111}, // R9 R3
      '{2'd3, 1'b1, 8'h3F,  32'h8000_0000, 5'b00100, 32'h8000_0000, 1'b1, 5'b00000}  // R9 R4 R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [31:0] operand = '0;
   logic [7:0]  bit_sel = '0;
   logic        size_long = 1'b0;
   logic [1:0]  op_code = '0;
   logic [4:0]  flags_in = '0;
   logic        res_valid;
   logic [31:0] result;
   logic        wr_en;
   logic [4:0]  flags_out;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   bittm_unit dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .operand   (operand),
      .bit_sel   (bit_sel),
      .size_long (size_long),
      .op_code   (op_code),
      .flags_in  (flags_in),
      .res_valid (res_valid),
      .result    (result),
      .wr_en     (wr_en),
      .flags_out (flags_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] op, input logic lng, input logic [7:0] sel,
                        input logic [31:0] opd, input logic [4:0] fin);
      @(negedge clk);
      op_valid  = 1'b1;
      op_code   = op;
      size_long = lng;
      bit_sel   = sel;
      operand   = opd;
      flags_in  = fin;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state, with a request pending
      op_valid = 1'b1;
      operand  = 32'hFFFF_FFFF;
      op_code  = 2'd3;
      flags_in = 5'b11111;
      repeat (3) @(negedge clk);
      chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
      chk("R1 wr_en",     {31'd0, wr_en},     32'd0);
      chk("R1 result",    result,             32'd0);
      chk("R1 flags_out", {27'd0, flags_out}, 32'd0);
      op_valid = 1'b0;
      rst_n    = 1'b1;

      // Vector table
      for (int i = 0; i < 8; i++) begin
         drive(VEC[i].op, VEC[i].lng, VEC[i].sel, VEC[i].opd, VEC[i].fin);
         chk("R2 res_valid",     {31'd0, res_valid}, 32'd1);
         chk("R3/R4 R6-R9 result", result, VEC[i].exp_res);
         chk("R6-R9 wr_en",      {31'd0, wr_en},     {31'd0, VEC[i].exp_wr});
         chk("R5 R10 flags_out", {27'd0, flags_out}, {27'd0, VEC[i].exp_fl});
      end

      // R2: idle cycle drops valid and write strobe
      @(negedge clk);
      op_valid = 1'b0;
      @(negedge clk);
      chk("R2 idle res_valid", {31'd0, res_valid}, 32'd0);
      chk("R2 idle wr_en",     {31'd0, wr_en},     32'd0);

      // R4: long sweep, bit number wraps at 32
      for (int i = 0; i < 64; i++) begin
         drive(2'd3, 1'b1, 8'(i), 32'd0, 5'b01011);
         chk("R4 long set", result, 32'd1 << (i % 32));
      end
      // R3: byte sweep, bit number wraps at 8
      for (int i = 0; i < 64; i++) begin
         drive(2'd3, 1'b0, 8'(i), 32'd0, 5'b10000);
         chk("R3 byte set", result, 32'd1 << (i % 8));
      end

      // R11 R8: clear of an already clear bit leaves word intact, Z set
      drive(2'd2, 1'b1, 8'd3, 32'hFFFF_FFF7, 5'b00000);
      chk("R11 clear zero bit", result, 32'hFFFF_FFF7);
      chk("R5 clear zero bit Z", {27'd0, flags_out}, 32'd4);
      // R9: set of an already set bit in byte mode, upper byte untouched
      drive(2'd3, 1'b0, 8'd7, 32'h5500_0080, 5'b11011);
      chk("R9 set set bit", result, 32'h5500_0080);
      chk("R10 set flags", {27'd0, flags_out}, {27'd0, 5'b11011});
      // R7: toggle back to zero in byte mode with high number
      drive(2'd1, 1'b0, 8'd255, 32'h0000_0080, 5'b00000);
      chk("R7 toggle clear", result, 32'h0000_0000);
      chk("R7 toggle wr_en", {31'd0, wr_en}, 32'd1);

      @(negedge clk);
      op_valid = 1'b0;
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule